// File: doc/BRIEF.md
# Startup Output Short Check Sequencer

This block runs a single check of the power-stage outputs when the supply first comes up, before any switching is allowed. It looks for any output shorted to ground, and then for any output shorted to the power rail. It drives a test-phase select to the analog test circuitry and reads back one comparator bit per half-bridge for each kind of short. While the check runs, or while a short is present, every half-bridge is held in high impedance and the active-low shutdown indicator stays low. When both phases pass, the indicator is released and a startup-done signal lets switching begin.

Each phase lasts a programmable settle count of clock cycles, so the time can be scaled to the output filter capacitance (roughly 15 ms per microfarad). At the end of each phase the comparators are sampled once. If any bit reports a short, the sequencer waits one more settle interval with the test idle and then starts again from the ground phase. It keeps retrying until the short clears. The check is skipped when the outputs are configured as single-ended. A device reset request has no effect while the check runs. After startup a device reset only gates switching and never starts the check again.

Top module: `short_check_seq`

## Requirements
- R1: After power-on reset, and for as long as `supplyGood` has not been seen high, the outputs hold at `testPhase`=00, `hizHold`=1, `shutdownN`=0, `startDone`=0. The check runs once only: a short reported on either comparator input after `startDone` has risen has no effect on any output.
- R2: In a bridged mode, the cycle after `supplyGood` is sampled high, `testPhase` becomes 01 (ground phase) for exactly SETTLE_CYCLES cycles. It then becomes 10 (rail phase) for exactly SETTLE_CYCLES cycles. With no short, the block then reaches the passed state.
- R3: A comparator bit at 1 means a short. If any `gndShort` bit is 1 at the end of the ground phase, or any `railShort` bit is 1 at the end of the rail phase, the block holds `testPhase`=00 for SETTLE_CYCLES cycles without passing, then restarts at the ground phase. This repeats for as long as the short persists.
- R4: Until the check passes, `hizHold`=1, `shutdownN`=0 and `startDone`=0. In the passed state `shutdownN`=1. When `devResetN` is also 1, `startDone`=1 and `hizHold`=0.
- R5: `devResetN` has no effect on the phase sequence or its timing while the check is in progress.
- R6: In the passed state, `devResetN`=0 immediately forces `startDone`=0 and `hizHold`=1, while `shutdownN` stays 1 and `testPhase` stays 00. Releasing it restores `startDone`=1 without running the check again.
- R7: When `cfgMode`=11 (single-ended) at the moment `supplyGood` is sampled, no test phase is entered and the passed state is reached on the next cycle. Modes 00, 01 and 10 run the check.
- R8: The length of each phase and each retry wait is set by the parameter SETTLE_CYCLES (at least 1). The number of half-bridges is set by NUM_HB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| supplyGood | input | 1 | Supply has arrived; starts the check |
| cfgMode | input | 2 | Output configuration; 11 = single-ended |
| devResetN | input | 1 | Device reset request, active low |
| gndShort | input | NUM_HB | Per-half-bridge short-to-ground comparator, 1 = short |
| railShort | input | NUM_HB | Per-half-bridge short-to-rail comparator, 1 = short |
| testPhase | output | 2 | 00 idle, 01 ground test, 10 rail test |
| hizHold | output | 1 | Hold all half-bridges in high impedance |
| shutdownN | output | 1 | Active-low shutdown indicator |
| startDone | output | 1 | Startup complete, switching allowed |

## Verification
A wrong settle count or a counter that fails to clear shows up as a phase boundary that is off by cycles. The bench compares `testPhase` against the expected segment every cycle, so a shift is caught on the first boundary, within one settle interval. A sequencer that mis-samples the comparators, uses the wrong comparator set, or skips the retry shows up as the wrong phase order, or as a pass while a short is held. Both are visible within two settle intervals of the fault. A terminal state that can be left again shows up as a test phase reappearing or `shutdownN` dropping after startup when shorts or reset requests are applied later.

// File: rtl/shortchk_pkg.sv
package shortchk_pkg;
  typedef enum logic [2:0] {
    ST_WAIT,
    ST_GND,
    ST_RAIL,
    ST_RETRY,
    ST_DONE
  } seqState_t;

  typedef struct packed {
    logic cntClear;
    logic cntRun;
    logic selRail;
  } dpCtl_t;

  localparam logic [1:0] PHASE_IDLE = 2'b00;
  localparam logic [1:0] PHASE_GND  = 2'b01;
  localparam logic [1:0] PHASE_RAIL = 2'b10;
  localparam logic [1:0] MODE_SE    = 2'b11;
endpackage

// File: rtl/shortchk_dp.sv
module shortchk_dp
  import shortchk_pkg::*;
#(
  parameter int NUM_HB        = 4,
  parameter int SETTLE_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [NUM_HB-1:0] gndShort,
  input  logic [NUM_HB-1:0] railShort,
  output logic              settleDone,
  output logic              shortHit
);
  localparam int CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0]     cnt;
  logic [NUM_HB-1:0] hitVec;

  // pick the comparator set for the active phase, per half-bridge
  genvar i;
  generate
    for (i = 0; i < NUM_HB; i++) begin : g_hb
      assign hitVec[i] = ctl.selRail ? railShort[i] : gndShort[i];
    end
  endgenerate

  assign shortHit   = |hitVec;
  assign settleDone = ctl.cntRun && (cnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.cntClear || settleDone) begin
      cnt <= '0;
    end else if (ctl.cntRun) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R8: the settle counter never runs past its programmed window
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    int'(cnt) < SETTLE_CYCLES);
endmodule

// File: rtl/shortchk_ctrl.sv
module shortchk_ctrl
  import shortchk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyGood,
  input  logic [1:0] cfgMode,
  input  logic       devResetN,
  input  logic       settleDone,
  input  logic       shortHit,
  output dpCtl_t     ctl,
  output logic [1:0] testPhase,
  output logic       hizHold,
  output logic       shutdownN,
  output logic       startDone
);
  seqState_t state, nextState;

  always_comb begin
    nextState    = state;
    ctl.cntClear = 1'b0;
    ctl.cntRun   = 1'b0;
    ctl.selRail  = (state == ST_RAIL);
    unique case (state)
      ST_WAIT: begin
        ctl.cntClear = 1'b1;
        if (supplyGood) nextState = (cfgMode == MODE_SE) ? ST_DONE : ST_GND;
      end
      ST_GND: begin
        ctl.cntRun = 1'b1;
        if (settleDone) nextState = shortHit ? ST_RETRY : ST_RAIL;
      end
      ST_RAIL: begin
        ctl.cntRun = 1'b1;
        if (settleDone) nextState = shortHit ? ST_RETRY : ST_DONE;
      end
      ST_RETRY: begin
        ctl.cntRun = 1'b1;
        if (settleDone) nextState = ST_GND;
      end
      ST_DONE: begin
        ctl.cntClear = 1'b1;
      end
      default: nextState = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_WAIT;
    else       state <= nextState;
  end

  always_comb begin
    unique case (state)
      ST_GND:  testPhase = PHASE_GND;
      ST_RAIL: testPhase = PHASE_RAIL;
      default: testPhase = PHASE_IDLE;
    endcase
  end

  // device reset only gates switching once startup has passed
  assign shutdownN = (state == ST_DONE);
  assign startDone = (state == ST_DONE) && devResetN;
  assign hizHold   = (state != ST_DONE) || !devResetN;

  // R6: once passed, the sequence is never entered again
  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE) |=> (state == ST_DONE));

  // R2: the rail phase is entered only straight from the ground phase
  assert_rail_after_gnd_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_RAIL) |-> ($past(state) == ST_GND));

  // R3: a short seen at the end of a phase keeps the outputs blocked
  assert_short_blocks_R3: assert property (@(posedge clk) disable iff (!rstN)
    (settleDone && shortHit && (state != ST_RETRY)) |=>
      (hizHold && !startDone && (testPhase == PHASE_IDLE)));

  // R7: single-ended configuration skips both phases
  assert_skip_se_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_WAIT) && supplyGood && (cfgMode == MODE_SE)) |=>
      (shutdownN && (testPhase == PHASE_IDLE)));
endmodule

// File: rtl/short_check_seq.sv
module short_check_seq
  import shortchk_pkg::*;
#(
  parameter int NUM_HB        = 4,
  parameter int SETTLE_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supplyGood,
  input  logic [1:0]        cfgMode,
  input  logic              devResetN,
  input  logic [NUM_HB-1:0] gndShort,
  input  logic [NUM_HB-1:0] railShort,
  output logic [1:0]        testPhase,
  output logic              hizHold,
  output logic              shutdownN,
  output logic              startDone
);
  dpCtl_t ctl;
  logic   settleDone;
  logic   shortHit;

  shortchk_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .supplyGood (supplyGood),
    .cfgMode    (cfgMode),
    .devResetN  (devResetN),
    .settleDone (settleDone),
    .shortHit   (shortHit),
    .ctl        (ctl),
    .testPhase  (testPhase),
    .hizHold    (hizHold),
    .shutdownN  (shutdownN),
    .startDone  (startDone)
  );

  shortchk_dp #(
    .NUM_HB        (NUM_HB),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .gndShort   (gndShort),
    .railShort  (railShort),
    .settleDone (settleDone),
    .shortHit   (shortHit)
  );

  // R4: switching is never granted while shutdown is indicated
  assert_shutdown_blocks_R4: assert property (@(posedge clk) disable iff (!rstN)
    !shutdownN |-> (!startDone && hizHold));
endmodule

// File: tb/tb_short_check_seq.sv
module tb_short_check_seq;
  localparam int NB = 2;
  localparam int S  = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          supplyGood = 1'b0;
  logic [1:0]    cfgMode = 2'b00;
  logic          devResetN = 1'b1;
  logic [NB-1:0] gndShort = '0;
  logic [NB-1:0] railShort = '0;
  logic [1:0]    testPhase;
  logic          hizHold, shutdownN, startDone;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  short_check_seq #(.NUM_HB(NB), .SETTLE_CYCLES(S)) dut (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .cfgMode(cfgMode),
    .devResetN(devResetN), .gndShort(gndShort), .railShort(railShort),
    .testPhase(testPhase), .hizHold(hizHold), .shutdownN(shutdownN),
    .startDone(startDone)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    rstN = 1'b0; supplyGood = 1'b0; devResetN = 1'b1;
    gndShort = '0; railShort = '0;
    tick();
    rstN = 1'b1;
    tick();
  endtask

  // kind 0: clean, 1: ground short first pass, 2: rail short first pass
  function automatic int segCount(input int kind);
    return (kind == 0) ? 2 : (kind == 1) ? 4 : 5;
  endfunction

  function automatic int segPhase(input int kind, input int seg);
    if (kind == 0) return (seg == 0) ? 1 : 2;
    if (kind == 1) begin
      case (seg) 0: return 1; 1: return 0; 2: return 1; default: return 2; endcase
    end
    case (seg) 0: return 1; 1: return 2; 2: return 0; 3: return 1; default: return 2; endcase
  endfunction

  task automatic runSeq(input logic [1:0] mode, input int kind, input int hb, input bit rstLow);
    int total;
    string tg;
    doReset();
    cfgMode = mode;
    if (kind == 1) gndShort[hb] = 1'b1;
    if (kind == 2) railShort[hb] = 1'b1;
    if (rstLow) devResetN = 1'b0;
    tg = rstLow ? "R5" : (kind == 0 ? "R2" : "R3");
    supplyGood = 1'b1;
    total = segCount(kind) * S + 1;
    for (int t = 1; t <= total; t++) begin
      int seg;
      bit inDone;
      tick();
      seg = (t - 1) / S;
      inDone = (seg >= segCount(kind));
      chk({tg, " phase"}, int'(testPhase), inDone ? 0 : segPhase(kind, seg));
      chk("R4 shutdownN", int'(shutdownN), int'(inDone));
      chk("R4 startDone", int'(startDone), int'(inDone && devResetN));
      chk("R4 hizHold", int'(hizHold), int'(!inDone || !devResetN));
      if (!inDone && kind != 0 && segPhase(kind, seg) == 0) begin
        gndShort = '0; railShort = '0;
      end
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state and waiting for supply
    doReset();
    chk("R1 reset phase", int'(testPhase), 0);
    chk("R1 reset hiz", int'(hizHold), 1);
    chk("R1 reset shutdownN", int'(shutdownN), 0);
    chk("R1 reset done", int'(startDone), 0);
    gndShort = '1;
    for (int t = 0; t < 3 * S; t++) begin
      tick();
      chk("R1 no supply phase", int'(testPhase), 0);
      chk("R1 no supply done", int'(startDone), 0);
    end

    // R2 R3 R7: sweep bridged modes, short kinds and half-bridges
    for (int m = 0; m < 3; m++) begin
      for (int k = 0; k < 3; k++) begin
        for (int b = 0; b < NB; b++) begin
          if (k == 0 && b > 0) continue;
          runSeq(2'(m), k, b, 1'b0);
          chk("R7 bridged mode passes", int'(startDone), 1);
        end
      end
    end

    // R5: reset request held low during the whole check
    runSeq(2'b00, 0, 0, 1'b1);
    runSeq(2'b10, 2, 1, 1'b1);

    // R6 and R1: after pass, reset gates switching and nothing reruns
    runSeq(2'b00, 0, 0, 1'b0);
    devResetN = 1'b0;
    #1;
    chk("R6 reset done", int'(startDone), 0);
    chk("R6 reset hiz", int'(hizHold), 1);
    chk("R6 reset shutdownN", int'(shutdownN), 1);
    for (int t = 0; t < 3 * S; t++) begin
      tick();
      chk("R6 no rerun phase", int'(testPhase), 0);
      chk("R6 held done", int'(startDone), 0);
    end
    devResetN = 1'b1;
    #1;
    chk("R6 release done", int'(startDone), 1);
    chk("R6 release hiz", int'(hizHold), 0);
    gndShort = '1; railShort = '1;
    for (int t = 0; t < 3 * S; t++) begin
      tick();
      chk("R1 late short done", int'(startDone), 1);
      chk("R1 late short shutdownN", int'(shutdownN), 1);
      chk("R1 late short phase", int'(testPhase), 0);
    end

    // R3: persistent short keeps retrying and never passes
    doReset();
    cfgMode = 2'b01;
    gndShort[1] = 1'b1;
    supplyGood = 1'b1;
    for (int t = 0; t < 6 * S; t++) begin
      tick();
      chk("R3 persistent done", int'(startDone), 0);
      chk("R3 persistent shutdownN", int'(shutdownN), 0);
      chk("R3 persistent no rail", int'(testPhase == 2'b10), 0);
    end
    gndShort = '0;
    for (int t = 0; t < 4 * S + 2; t++) tick();
    chk("R3 clears and passes", int'(startDone), 1);

    // R7: single-ended skips the check even with shorts present
    doReset();
    cfgMode = 2'b11;
    gndShort = '1; railShort = '1;
    supplyGood = 1'b1;
    tick();
    chk("R7 skip done", int'(startDone), 1);
    chk("R7 skip phase", int'(testPhase), 0);
    chk("R7 skip shutdownN", int'(shutdownN), 1);

    // R8: ground phase width equals the settle parameter
    doReset();
    cfgMode = 2'b00;
    supplyGood = 1'b1;
    begin
      int width = 0;
      tick();
      while (testPhase == 2'b01 && width < 10 * S) begin
        width++;
        tick();
      end
      chk("R8 phase width", width, S);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule